// File: doc/BRIEF.md
# Conditional Trap Decision Unit

This block sits in the execute stage of a 32-bit processor pipeline. It decides whether a conditional trap instruction fires. Each cycle it receives an instruction word and the two operand values read from the register file. It recognises the register-register and register-immediate trap forms, then performs the equality, signed or unsigned ordering comparison that the form selects.

Two results are registered for one pipeline stage:

- a trap request, raised only when the selected condition holds;
- a flag marking the instruction as a recognised trap.

Exception entry, saving the return address and pipeline flushing belong to the surrounding core. A stall input freezes the stage, and a cycle without a valid input leaves a bubble of zeros.

Top module: `trap_decide_unit`

## Requirements
- R1: While the synchronous active-low reset is sampled low at a clock edge, both `trap_req` and `is_trap` are 0 after that edge.
- R2: Opcode bits 31:26 = 000000 selects the register-register forms, which compare `src_a` against `src_b`. The function field in bits 5:0 selects the condition: 110100 equal, 110110 not equal, 110000 greater-or-equal signed, 110001 greater-or-equal unsigned, 110010 less-than signed, 110011 less-than unsigned. The code field in bits 15:6 has no effect on the outcome.
- R3: Opcode bits 31:26 = 000001 selects the immediate forms, which compare `src_a` against the immediate in bits 15:0. The selector in bits 20:16 picks the condition: 01100 equal, 01110 not equal, 01000 greater-or-equal signed, 01001 greater-or-equal unsigned, 01010 less-than signed, 01011 less-than unsigned. `src_b` has no effect on the outcome of these forms.
- R4: The 16-bit immediate is sign-extended to 32 bits for every immediate form, the unsigned forms included.
- R5: The unsigned conditions compare both 32-bit values as unsigned numbers. All other conditions compare them as two's-complement signed numbers.
- R6: For a recognised trap, `is_trap` is 1. `trap_req` is 1 only if the selected condition holds, so `trap_req` is never 1 while `is_trap` is 0.
- R7: Any other opcode, function code or selector value gives `trap_req` = 0 and `is_trap` = 0.
- R8: An input accepted at a clock edge shows its results on the outputs from that edge until the next one. Before that edge the outputs keep the previous results.
- R9: While `stall` is 1 at a clock edge, both outputs keep their values, whatever `in_valid` and the other inputs are.
- R10: With `stall` = 0 and `in_valid` = 0 at a clock edge, both outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| stall | input | 1 | Hold the registered results |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand (used by the register-register forms only) |
| trap_req | output | 1 | Registered trap request |
| is_trap | output | 1 | Registered recognised-trap flag |

## Verification
Both results pass through exactly one register, so each becomes due at the first rising edge after the input is presented. The bench drives on the falling edge and samples on the following falling edge, half a cycle after the capturing edge. One directed test also samples just before the capturing edge to confirm that the old value is still there. Stall, bubble and reset tests sample each held or cleared value one edge later, using the same half-cycle offset.

// File: rtl/trap_decide_pkg.sv
package trap_decide_pkg;

    // Comparison selected by a decoded trap instruction
    typedef enum logic [2:0] {
        CMP_EQ   = 3'd0,
        CMP_NE   = 3'd1,
        CMP_GE_S = 3'd2,
        CMP_GE_U = 3'd3,
        CMP_LT_S = 3'd4,
        CMP_LT_U = 3'd5
    } cmp_kind_e;

    typedef struct packed {
        logic      hit;       // instruction is one of the trap forms
        logic      imm_form;  // second operand comes from the immediate
        cmp_kind_e kind;
    } trap_dec_t;

    typedef struct packed {
        logic fire;
        logic known;
    } trap_stage_t;

    // Field positions of the instruction word
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 26;
    localparam int SEL_HI = 20;
    localparam int SEL_LO = 16;
    localparam int FN_HI  = 5;
    localparam int FN_LO  = 0;

    localparam logic [5:0] OPC_REGREG = 6'b000000;
    localparam logic [5:0] OPC_REGIMM = 6'b000001;

endpackage

// File: rtl/trap_op_decode.sv
module trap_op_decode
    import trap_decide_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output trap_dec_t         dec
);
    logic [OPC_HI-OPC_LO:0] opc;
    logic [SEL_HI-SEL_LO:0] sel;
    logic [FN_HI-FN_LO:0]   fn;
    logic                   unused_fields;

    assign opc = insn[OPC_HI:OPC_LO];
    assign sel = insn[SEL_HI:SEL_LO];
    assign fn  = insn[FN_HI:FN_LO];
    // source register number and code field do not affect the decision
    assign unused_fields = ^{insn[INSN_W-1-(OPC_HI-OPC_LO+1):SEL_HI+1], insn[SEL_LO-1:FN_HI+1]};

    always_comb begin
        dec = '{hit: 1'b0, imm_form: 1'b0, kind: CMP_EQ};
        if (opc == OPC_REGREG) begin
            dec.hit = 1'b1;
            unique case (fn)
                6'b110100: dec.kind = CMP_EQ;
                6'b110110: dec.kind = CMP_NE;
                6'b110000: dec.kind = CMP_GE_S;
                6'b110001: dec.kind = CMP_GE_U;
                6'b110010: dec.kind = CMP_LT_S;
                6'b110011: dec.kind = CMP_LT_U;
                default:   dec.hit  = 1'b0;
            endcase
        end else if (opc == OPC_REGIMM) begin
            dec.hit      = 1'b1;
            dec.imm_form = 1'b1;
            unique case (sel)
                5'b01100: dec.kind = CMP_EQ;
                5'b01110: dec.kind = CMP_NE;
                5'b01000: dec.kind = CMP_GE_S;
                5'b01001: dec.kind = CMP_GE_U;
                5'b01010: dec.kind = CMP_LT_S;
                5'b01011: dec.kind = CMP_LT_U;
                default: begin
                    dec.hit      = 1'b0;
                    dec.imm_form = 1'b0;
                end
            endcase
        end
    end

    // R7: only the two trap opcode classes may be recognised
    always_comb begin
        assert_opcode_class_R7: assert (!(dec.hit && opc[OPC_HI-OPC_LO:1] != '0));
    end

endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
    import trap_decide_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  cmp_kind_e         kind,
    output logic              holds
);
    logic eq;
    logic lt_s;
    logic lt_u;

    assign eq   = (lhs == rhs);
    assign lt_u = (lhs < rhs);
    assign lt_s = ($signed(lhs) < $signed(rhs));

    always_comb begin
        unique case (kind)
            CMP_EQ:   holds = eq;
            CMP_NE:   holds = !eq;
            CMP_GE_S: holds = !lt_s;
            CMP_GE_U: holds = !lt_u;
            CMP_LT_S: holds = lt_s;
            CMP_LT_U: holds = lt_u;
            default:  holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/trap_decide_unit.sv
module trap_decide_unit
    import trap_decide_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              stall,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              trap_req,
    output logic              is_trap
);
    localparam int EXT_W = DATA_W - IMM_W;

    trap_dec_t         dec;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] rhs;
    logic              cond_ok;
    trap_stage_t       stage_d;
    trap_stage_t       stage_q;

    trap_op_decode #(.INSN_W(32)) u_decode (
        .insn (insn),
        .dec  (dec)
    );

    // sign extension applies to the unsigned forms too
    assign imm_ext = {{EXT_W{insn[IMM_W-1]}}, insn[IMM_W-1:0]};
    assign rhs     = dec.imm_form ? imm_ext : src_b;

    trap_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .lhs   (src_a),
        .rhs   (rhs),
        .kind  (dec.kind),
        .holds (cond_ok)
    );

    always_comb begin
        stage_d = stage_q;
        if (!stall) begin
            if (in_valid) begin
                stage_d.known = dec.hit;
                stage_d.fire  = dec.hit && cond_ok;
            end else begin
                stage_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign trap_req = stage_q.fire;
    assign is_trap  = stage_q.known;

    // R9: stall freezes both results
    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(trap_req) && $stable(is_trap)));

    // R10: an empty cycle leaves a bubble
    assert_bubble_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !in_valid) |=> (!trap_req && !is_trap));

    // R6: a request is only raised for a recognised trap
    assert_req_needs_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> is_trap);

    // R7: foreign opcodes never register as traps
    assert_foreign_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall && insn[31:27] != 5'b0) |=> !is_trap);

endmodule

// File: tb/trap_decide_unit_tb_top.sv
module trap_decide_unit_tb_top;

    typedef struct packed {
        logic [23:0] req;
        logic [31:0] insn;
        logic [31:0] a;
        logic [31:0] b;
        logic        fire;
        logic        known;
    } vec_t;

    function automatic logic [31:0] rr(input logic [5:0] fn, input logic [9:0] code);
        return {6'b000000, 5'd4, 5'd5, code, fn};
    endfunction

    function automatic logic [31:0] ri(input logic [4:0] sel, input logic [15:0] imm);
        return {6'b000001, 5'd3, sel, imm};
    endfunction

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{"R2",  rr(6'b110100, 10'h000), 32'h5,        32'h5,        1'b1, 1'b1},
        '{"R2",  rr(6'b110100, 10'h3A5), 32'h5,        32'h5,        1'b1, 1'b1},
        '{"R6",  rr(6'b110100, 10'h000), 32'h5,        32'h6,        1'b0, 1'b1},
        '{"R2",  rr(6'b110110, 10'h011), 32'h5,        32'h6,        1'b1, 1'b1},
        '{"R5",  rr(6'b110000, 10'h000), 32'hFFFFFFFF, 32'h1,        1'b0, 1'b1},
        '{"R5",  rr(6'b110001, 10'h000), 32'hFFFFFFFF, 32'h1,        1'b1, 1'b1},
        '{"R5",  rr(6'b110010, 10'h000), 32'hFFFFFFFF, 32'h1,        1'b1, 1'b1},
        '{"R5",  rr(6'b110011, 10'h000), 32'hFFFFFFFF, 32'h1,        1'b0, 1'b1},
        '{"R5",  rr(6'b110000, 10'h000), 32'h7,        32'h7,        1'b1, 1'b1},
        '{"R5",  rr(6'b110010, 10'h000), 32'h7,        32'h7,        1'b0, 1'b1},
        '{"R4",  ri(5'b01100, 16'hFFFF), 32'hFFFFFFFF, 32'h0,        1'b1, 1'b1},
        '{"R4",  ri(5'b01011, 16'h8000), 32'h00008000, 32'h0,        1'b1, 1'b1},
        '{"R4",  ri(5'b01001, 16'hFFFF), 32'hFFFFFFFF, 32'h0,        1'b1, 1'b1},
        '{"R5",  ri(5'b01010, 16'h8000), 32'hFFFF7FFF, 32'h0,        1'b1, 1'b1},
        '{"R3",  ri(5'b01000, 16'h0001), 32'h0,        32'h0,        1'b0, 1'b1},
        '{"R3",  ri(5'b01110, 16'h0001), 32'h1,        32'h0,        1'b0, 1'b1},
        '{"R3",  ri(5'b01100, 16'h0005), 32'h5,        32'h7,        1'b1, 1'b1},
        '{"R7",  rr(6'b110101, 10'h000), 32'h5,        32'h5,        1'b0, 1'b0},
        '{"R7",  {6'b000010, 26'h0}, 32'h5,        32'h5,        1'b0, 1'b0},
        '{"R7",  ri(5'b01101, 16'h0005), 32'h5,        32'h5,        1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        trap_req;
    logic        is_trap;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    trap_decide_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .stall    (stall),
        .insn     (insn),
        .src_a    (src_a),
        .src_b    (src_b),
        .trap_req (trap_req),
        .is_trap  (is_trap)
    );

    task automatic check(input string req, input logic exp_fire, input logic exp_known);
        n_checks++;
        if (trap_req !== exp_fire || is_trap !== exp_known) begin
            n_fails++;
            $display("FAIL %s: trap_req=%b is_trap=%b expected trap_req=%b is_trap=%b",
                     req, trap_req, is_trap, exp_fire, exp_known);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic [31:0] i,
                         input logic [31:0] a, input logic [31:0] b);
        in_valid = v; stall = s; insn = i; src_a = a; src_b = b;
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;

        // table walk: drive on a falling edge, sample one falling edge later
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(1'b1, 1'b0, VEC[k].insn, VEC[k].a, VEC[k].b);
            @(negedge clk);
            check(string'(VEC[k].req), VEC[k].fire, VEC[k].known);
        end

        // R10: bubble
        drive(1'b0, 1'b0, rr(6'b110100, 10'h0), 32'h1, 32'h1);
        @(negedge clk);
        check("R10", 1'b0, 1'b0);

        // R8: old value holds until the capturing edge
        drive(1'b1, 1'b0, rr(6'b110100, 10'h0), 32'h9, 32'h9);
        #1;
        check("R8", 1'b0, 1'b0);
        @(negedge clk);
        check("R8", 1'b1, 1'b1);

        // R9: stall with a different valid instruction, then with valid low
        drive(1'b1, 1'b1, {6'b000010, 26'h0}, 32'h0, 32'h1);
        @(negedge clk);
        check("R9", 1'b1, 1'b1);
        drive(1'b0, 1'b1, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        check("R9", 1'b1, 1'b1);
        drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        check("R10", 1'b0, 1'b0);

        // R9: stall while holding a recognised but not firing result
        drive(1'b1, 1'b0, rr(6'b110110, 10'h0), 32'h3, 32'h3);
        @(negedge clk);
        check("R6", 1'b0, 1'b1);
        drive(1'b1, 1'b1, rr(6'b110110, 10'h0), 32'h3, 32'h4);
        @(negedge clk);
        check("R9", 1'b0, 1'b1);

        // R1: reset during operation clears a firing result
        drive(1'b1, 1'b0, ri(5'b01000, 16'h0000), 32'h1, 32'h0);
        @(negedge clk);
        check("R3", 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule